// File: doc/BRIEF.md
# Adaptive Prefetch Usefulness Throttle

This block decides how many startup prefetches a cache's prefetcher may issue by watching what happens to prefetched lines after they arrive. Every way of a cache set, including ways that hold only an address tag with no data behind it, carries a prefetch-marker bit. The block is shown one set per cycle, together with that set's marker and data-present vectors and the events that occurred on it. From these it returns the updated marker vector for the tag array to write back, and it steps an internal saturating budget counter.

A hit on a marked way means the prefetch paid off, and the budget rises by one. Replacing a marked way means the prefetch was never used, and the budget falls by one. A miss that matches a tag whose data has been dropped, while some other way still holds marked data, is treated as a miss that the prefetch caused. The budget falls by one for that as well. Events that arrive in the same cycle are combined into one net step, and that step is clamped to the legal range.

Top module: `pfu_throttle`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `pf_limit_o` equals MAX_PF.
- R2: For an allocation into way `alloc_way_i`, bit `alloc_way_i` of `pf_next_o` equals `alloc_pf_i`. A prefetch allocation sets the bit. A demand allocation leaves it clear. Allocation takes precedence over any other event on the same way.
- R3: A hit on way `hit_way_i` clears bit `hit_way_i` of `pf_next_o`. Ways that no event touches pass their `set_pf_i` bit through unchanged. Bit i of every way vector refers to way i.
- R4: A replacement of way `repl_way_i` clears bit `repl_way_i` of `pf_next_o`.
- R5: A hit on a way whose `set_pf_i` bit is 1 is a useful prefetch. On its own, it raises `pf_limit_o` by one on the next cycle.
- R6: A replacement of a way whose `set_pf_i` bit is 1 is a useless prefetch. On its own, it lowers `pf_limit_o` by one on the next cycle. Replacing an unmarked way is not classified.
- R7: A tag-only miss is harmful when it meets two conditions. The matched way has `set_valid_i` 0, and at least one way has both `set_valid_i` and `set_pf_i` at 1. On its own, a harmful miss lowers `pf_limit_o` by one. Marker bits on data-less ways do not count.
- R8: `pf_limit_o` never leaves the range 0 to MAX_PF. A rise at MAX_PF and a fall at 0 both leave it unchanged.
- R9: Events in the same cycle apply a net step of +1 per useful minus 1 per useless and minus 1 per harmful. The result is then clamped to the range.
- R10: A cycle with no useful, useless or harmful event leaves `pf_limit_o` unchanged. Hits on unmarked ways and allocations count as such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_pf_i | input | WAYS | Current prefetch-marker bits of the set |
| set_valid_i | input | WAYS | Data-present bits of the set |
| hit_vld_i | input | 1 | A hit occurred this cycle |
| hit_way_i | input | WW | Way index of the hit |
| repl_vld_i | input | 1 | A valid line is replaced this cycle |
| repl_way_i | input | WW | Way index being replaced |
| tmiss_vld_i | input | 1 | A miss matched a stored tag this cycle |
| tmiss_way_i | input | WW | Way index whose tag matched |
| alloc_vld_i | input | 1 | A line is allocated this cycle |
| alloc_way_i | input | WW | Way index being allocated |
| alloc_pf_i | input | 1 | The allocation is a prefetch (1) or demand (0) |
| pf_next_o | output | WAYS | Marker vector to write back to the set |
| pf_limit_o | output | CW | Startup prefetch budget |

## Verification
The hardest case to reach is the harmful miss. It requires a data-less way whose tag matches, while a different way holds data and is still marked. It must also be told apart from the case where only data-less ways carry markers. The stimulus reaches it by sweeping every combination of marker and data-present vectors against every tag-miss way, with a hit interleaved to pull the budget off zero. A second sweep crosses hits, replacements and allocations on fully valid sets. That sweep pushes the budget through both clamps and through the cases where events cancel.

// File: rtl/pfu_pkg.sv
// Shared types for the prefetch usefulness throttle.
package pfu_pkg;
    // Classification of the events seen in one cycle.
    typedef struct packed {
        logic useful;
        logic useless;
        logic harmful;
    } pfu_class_t;
endpackage

// File: rtl/pfu_classify.sv
// Classifies one cycle of set events into useful, useless and harmful.
// Assumes that all events in a cycle refer to the same set, and that the
// caller only flags a tag-only miss when the matched tag was found.
module pfu_classify
    import pfu_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int WW   = 2
) (
    input  logic [WAYS-1:0] set_pf_i,
    input  logic [WAYS-1:0] set_valid_i,
    input  logic            hit_vld_i,
    input  logic [WW-1:0]   hit_way_i,
    input  logic            repl_vld_i,
    input  logic [WW-1:0]   repl_way_i,
    input  logic            tmiss_vld_i,
    input  logic [WW-1:0]   tmiss_way_i,
    output pfu_class_t      cls_o
);
    logic [WAYS-1:0] other_mask;

    // Build a mask that excludes the matched way from the marked-data search.
    for (genvar g = 0; g < WAYS; g++) begin : g_mask
        assign other_mask[g] = (tmiss_way_i != WW'(g));
    end

    // Combine the event strobes with the marker and data-present bits.
    always_comb begin
        cls_o.useful  = hit_vld_i && set_pf_i[hit_way_i];
        cls_o.useless = repl_vld_i && set_pf_i[repl_way_i];
        cls_o.harmful = tmiss_vld_i && !set_valid_i[tmiss_way_i]
                        && (|(set_pf_i & set_valid_i & other_mask));
    end
endmodule

// File: rtl/pfu_pfbits.sv
// Computes the marker vector to write back to the set after this cycle.
// Order of effect per way: a hit or replacement clears the bit, and an
// allocation then writes its prefetch flag over the result.
module pfu_pfbits #(
    parameter int WAYS = 4,
    parameter int WW   = 2
) (
    input  logic [WAYS-1:0] set_pf_i,
    input  logic            hit_vld_i,
    input  logic [WW-1:0]   hit_way_i,
    input  logic            repl_vld_i,
    input  logic [WW-1:0]   repl_way_i,
    input  logic            alloc_vld_i,
    input  logic [WW-1:0]   alloc_way_i,
    input  logic            alloc_pf_i,
    output logic [WAYS-1:0] pf_next_o
);
    // Per-way update of the marker bit.
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic clr, wr;
        assign clr = (hit_vld_i && hit_way_i == WW'(g))
                  || (repl_vld_i && repl_way_i == WW'(g));
        assign wr  = alloc_vld_i && alloc_way_i == WW'(g);
        assign pf_next_o[g] = wr ? alloc_pf_i : (set_pf_i[g] && !clr);
    end
endmodule

// File: rtl/pfu_satcnt.sv
// Saturating budget counter that takes a net step each cycle.
// Assumes MAX_PF >= 3, so that the counter width covers a two-step decrement.
module pfu_satcnt
    import pfu_pkg::*;
#(
    parameter int MAX_PF = 7,
    parameter int CW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pfu_class_t    cls_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] MAX_V = CW'(MAX_PF);

    logic [1:0]    dec_n;
    logic [1:0]    dec_eff;
    logic [CW-1:0] cnt_q, cnt_d;

    // Net step: increments and decrements cancel, and the rest is clamped.
    always_comb begin
        dec_n   = 2'(cls_i.useless) + 2'(cls_i.harmful);
        dec_eff = cls_i.useful ? dec_n - 2'd1 : dec_n;
        if (cls_i.useful && dec_n == 2'd0)
            cnt_d = (cnt_q == MAX_V) ? cnt_q : cnt_q + 1'b1;
        else if (cnt_q < CW'(dec_eff))
            cnt_d = '0;
        else
            cnt_d = cnt_q - CW'(dec_eff);
    end

    // Budget register: resets to full so prefetching starts enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= MAX_V;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pfu_throttle.sv
// Top of the prefetch usefulness throttle. Takes one set's events per cycle,
// returns that set's updated marker bits and keeps the prefetch budget.
// Assumes the tag array writes pf_next_o back to the same set each cycle.
module pfu_throttle
    import pfu_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int MAX_PF = 7,
    parameter int WW     = (WAYS > 1) ? $clog2(WAYS) : 1,
    parameter int CW     = $clog2(MAX_PF + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WAYS-1:0] set_pf_i,
    input  logic [WAYS-1:0] set_valid_i,
    input  logic            hit_vld_i,
    input  logic [WW-1:0]   hit_way_i,
    input  logic            repl_vld_i,
    input  logic [WW-1:0]   repl_way_i,
    input  logic            tmiss_vld_i,
    input  logic [WW-1:0]   tmiss_way_i,
    input  logic            alloc_vld_i,
    input  logic [WW-1:0]   alloc_way_i,
    input  logic            alloc_pf_i,
    output logic [WAYS-1:0] pf_next_o,
    output logic [CW-1:0]   pf_limit_o
);
    pfu_class_t cls;

    pfu_classify #(.WAYS(WAYS), .WW(WW)) u_classify (
        .set_pf_i   (set_pf_i),
        .set_valid_i(set_valid_i),
        .hit_vld_i  (hit_vld_i),
        .hit_way_i  (hit_way_i),
        .repl_vld_i (repl_vld_i),
        .repl_way_i (repl_way_i),
        .tmiss_vld_i(tmiss_vld_i),
        .tmiss_way_i(tmiss_way_i),
        .cls_o      (cls)
    );

    pfu_pfbits #(.WAYS(WAYS), .WW(WW)) u_pfbits (
        .set_pf_i   (set_pf_i),
        .hit_vld_i  (hit_vld_i),
        .hit_way_i  (hit_way_i),
        .repl_vld_i (repl_vld_i),
        .repl_way_i (repl_way_i),
        .alloc_vld_i(alloc_vld_i),
        .alloc_way_i(alloc_way_i),
        .alloc_pf_i (alloc_pf_i),
        .pf_next_o  (pf_next_o)
    );

    pfu_satcnt #(.MAX_PF(MAX_PF), .CW(CW)) u_satcnt (
        .clk  (clk),
        .rst_n(rst_n),
        .cls_i(cls),
        .cnt_o(pf_limit_o)
    );
endmodule

// File: rtl/pfu_throttle_chk.sv
// Property checker for pfu_throttle, attached through bind.
module pfu_throttle_chk #(
    parameter int WAYS   = 4,
    parameter int MAX_PF = 7,
    parameter int WW     = 2,
    parameter int CW     = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [WAYS-1:0] set_pf_i,
    input logic [WAYS-1:0] set_valid_i,
    input logic            hit_vld_i,
    input logic [WW-1:0]   hit_way_i,
    input logic            repl_vld_i,
    input logic [WW-1:0]   repl_way_i,
    input logic            tmiss_vld_i,
    input logic [WW-1:0]   tmiss_way_i,
    input logic            alloc_vld_i,
    input logic [WW-1:0]   alloc_way_i,
    input logic            alloc_pf_i,
    input logic [WAYS-1:0] pf_next_o,
    input logic [CW-1:0]   pf_limit_o
);
    localparam logic [CW-1:0] MAX_V = CW'(MAX_PF);

    AST_RESET_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pf_limit_o == MAX_V); // R1

    AST_ALLOC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_vld_i |-> pf_next_o[alloc_way_i] == alloc_pf_i); // R2

    AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld_i && !(alloc_vld_i && alloc_way_i == hit_way_i)
        |-> !pf_next_o[hit_way_i]); // R3

    AST_REPL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        repl_vld_i && !(alloc_vld_i && alloc_way_i == repl_way_i)
        |-> !pf_next_o[repl_way_i]); // R4

    AST_USEFUL_UP: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld_i && set_pf_i[hit_way_i] && !repl_vld_i && !tmiss_vld_i
        && pf_limit_o != MAX_V |=> pf_limit_o == $past(pf_limit_o) + 1'b1); // R5

    AST_USELESS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        repl_vld_i && set_pf_i[repl_way_i] && !hit_vld_i && !tmiss_vld_i
        && pf_limit_o != '0 |=> pf_limit_o == $past(pf_limit_o) - 1'b1); // R6

    AST_HARMFUL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        tmiss_vld_i && !set_valid_i[tmiss_way_i] && (|(set_pf_i & set_valid_i))
        && !hit_vld_i && !repl_vld_i && pf_limit_o != '0
        |=> pf_limit_o == $past(pf_limit_o) - 1'b1); // R7

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_limit_o <= MAX_V); // R8

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_vld_i && !repl_vld_i && !tmiss_vld_i |=> $stable(pf_limit_o)); // R10
endmodule

bind pfu_throttle pfu_throttle_chk #(
    .WAYS(WAYS), .MAX_PF(MAX_PF), .WW(WW), .CW(CW)
) u_chk (.*);

// File: tb/pfu_throttle_bench.sv
// Sweeps marker, data-present and event combinations on a 4-way set with
// MAX_PF = 5, and compares against a budget and marker model in the bench.
module pfu_throttle_bench;
    localparam int WAYS = 4;
    localparam int MAXP = 5;
    localparam int WW   = 2;
    localparam int CW   = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic [WAYS-1:0] set_pf_i = '0, set_valid_i = '0;
    logic hit_vld_i = 0, repl_vld_i = 0, tmiss_vld_i = 0, alloc_vld_i = 0, alloc_pf_i = 0;
    logic [WW-1:0] hit_way_i = '0, repl_way_i = '0, tmiss_way_i = '0, alloc_way_i = '0;
    logic [WAYS-1:0] pf_next_o;
    logic [CW-1:0] pf_limit_o;

    int total = 0, bad = 0;
    int model = MAXP;
    string ctag = "R1";

    always #10 clk = ~clk;

    pfu_throttle #(.WAYS(WAYS), .MAX_PF(MAXP)) u_pfu_throttle (.*);

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: check the previous budget, drive events, check markers, update the model.
    task automatic step(input logic [3:0] p, input logic [3:0] v,
                        input logic hv, input int hw, input logic rv, input int rw,
                        input logic tv, input int tw, input logic av, input int aw,
                        input logic apf);
        logic [3:0] ep;
        logic uf, ul, hm;
        int nx;
        @(negedge clk);
        check(ctag, int'(pf_limit_o), model);
        set_pf_i = p; set_valid_i = v;
        hit_vld_i = hv; hit_way_i = WW'(hw);
        repl_vld_i = rv; repl_way_i = WW'(rw);
        tmiss_vld_i = tv; tmiss_way_i = WW'(tw);
        alloc_vld_i = av; alloc_way_i = WW'(aw); alloc_pf_i = apf;
        ep = p;
        if (hv) ep[hw] = 1'b0;
        if (rv) ep[rw] = 1'b0;
        if (av) ep[aw] = apf;
        #2;
        if (av)      check("R2", int'(pf_next_o), int'(ep));
        else if (rv) check("R4", int'(pf_next_o), int'(ep));
        else         check("R3", int'(pf_next_o), int'(ep));
        uf = hv && p[hw];
        ul = rv && p[rw];
        hm = 1'b0;
        if (tv && !v[tw])
            for (int k = 0; k < WAYS; k++) if (k != tw && p[k] && v[k]) hm = 1'b1;
        nx = model + int'(uf) - int'(ul) - int'(hm);
        if (uf && (ul || hm))            ctag = "R9";
        else if (nx > MAXP || nx < 0)    ctag = "R8";
        else if (uf)                     ctag = "R5";
        else if (hm)                     ctag = "R7";
        else if (ul)                     ctag = "R6";
        else                             ctag = "R10";
        if (nx > MAXP) nx = MAXP;
        if (nx < 0) nx = 0;
        model = nx;
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(pf_limit_o), MAXP);
        rst_n = 1;
        // Harmful-miss sweep with a hit mixed in to lift the budget (R7).
        for (int p = 0; p < 16; p++)
            for (int v = 0; v < 16; v++)
                for (int t = 0; t < 5; t++)
                    for (int h = 0; h < 5; h++)
                        step(4'(p), 4'(v), h < 4, h % 4, 0, 0, t < 4, t % 4, 0, 0, 0);
        // Hit, replacement and allocation sweep on fully valid sets (R2 R3 R4 R5 R6 R9).
        for (int p = 0; p < 16; p++)
            for (int h = 0; h < 5; h++)
                for (int r = 0; r < 5; r++)
                    for (int a = 0; a < 9; a++)
                        step(4'(p), 4'hF, h < 4, h % 4, r < 4, r % 4, 0, 0,
                             a < 8, (a % 8) >> 1, a[0]);
        // Directed clamps at both ends (R8).
        for (int i = 0; i < 8; i++) step(4'h1, 4'hF, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) step(4'h2, 4'hF, 0, 0, 1, 1, 0, 0, 0, 0, 0);
        // Quiet cycles and a demand allocation (R10, R2).
        for (int i = 0; i < 3; i++) step(4'h0, 4'hF, 0, 0, 0, 0, 0, 0, 1, i, 0);
        @(negedge clk);
        check(ctag, int'(pf_limit_o), model);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule